// File: doc/BRIEF.md
# Single-Wire Parity Byte Transceiver

This block carries one byte at a time over a single shared data wire. Each frame opens with a sync pulse. The sender pulls the wire low for one bit period and then drives it high for a short marker. The data bits follow, most significant bit first, and then one even-parity bit. After the parity bit the sender keeps the wire low. The next frame's sync pulse therefore always begins from low and gives the receiver a clean rising edge.

The transmit half starts on a one-cycle strobe and reports a one-cycle done pulse. It drives the wire only through an output-enable and an output-value pair, so the surrounding logic can build an open-drain or a tristate pad from them. The receive half is armed by a one-cycle strobe. It passes the wire through a two-flop synchroniser and waits a bounded time for the wire to fall. It then times every bit from the rising edge that follows. It samples each bit at the middle of its period and ends with a done pulse that carries the byte and a parity-error flag. The bit period and the marker length are parameters counted in clock cycles.

Top module: `sw_parity_xcvr`

## Requirements
- R1: After reset, line_oe, tx_busy, tx_done, rx_busy and rx_done are 0, rx_data is 0 and rx_perr is 0.
- R2: When tx_start is high in a clock cycle while tx_busy is low, the transmitter drives the wire (line_oe=1) from the next cycle on. It holds line_out=0 for BIT_CYCLES cycles and then line_out=1 for MARK_CYCLES cycles.
- R3: The data bits follow the marker, most significant bit first, and each bit is held for BIT_CYCLES cycles.
- R4: A parity bit follows the last data bit for BIT_CYCLES cycles. Its value is the XOR of the data bits, so the data bits and the parity bit together hold an even number of ones.
- R5: In the cycle after the parity period, tx_done is 1 for exactly one cycle and tx_busy falls. From that cycle on, line_oe=1 and line_out=0 are held until the next accepted start.
- R6: A tx_start while tx_busy is high is ignored. The wire keeps the waveform of the byte that was accepted.
- R7: An rx_arm accepted while rx_busy is low makes the receiver wait for the synchronised wire to be low. On a low, it then waits without limit for the wire to be high, and that cycle is the timing reference.
- R8: Bit k (k=0 for the most significant data bit, k=DATA_BITS for the parity bit) is sampled MARK_CYCLES + BIT_CYCLES/2 + k*BIT_CYCLES cycles after the reference. rx_done pulses for one cycle BIT_CYCLES - BIT_CYCLES/2 + 1 cycles after the parity sample. With the two-flop synchroniser, rx_done appears 3 + MARK_CYCLES + (DATA_BITS+1)*BIT_CYCLES cycles after the first cycle the wire is high.
- R9: rx_perr is 1 when the received data bits and parity bit hold an odd number of ones. The byte is still delivered on rx_data. rx_data and rx_perr change only in a cycle where rx_done is 1.
- R10: If the wire is not seen low within WAIT_PERIODS*BIT_CYCLES cycles of arming, the last waiting cycle becomes the reference. A wire held high then yields rx_data=all ones, rx_perr=1, and rx_done WAIT_PERIODS*BIT_CYCLES + MARK_CYCLES + (DATA_BITS+1)*BIT_CYCLES + 1 cycles after the arming cycle.
- R11: An rx_arm while rx_busy is high is ignored and does not disturb the frame in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_start | input | 1 | Start strobe for a transmit frame |
| tx_data | input | DATA_BITS | Byte to send, sampled with tx_start |
| tx_busy | output | 1 | Transmit frame in progress |
| tx_done | output | 1 | One-cycle pulse at the end of a transmit frame |
| line_oe | output | 1 | Drive enable for the wire |
| line_out | output | 1 | Value driven on the wire when line_oe is 1 |
| line_in | input | 1 | Wire level as seen at the pad |
| rx_arm | input | 1 | Arms the receiver for one frame |
| rx_busy | output | 1 | Receive frame in progress |
| rx_done | output | 1 | One-cycle pulse, rx_data and rx_perr valid |
| rx_data | output | DATA_BITS | Last received byte |
| rx_perr | output | 1 | Parity error on the last received byte |

## Verification
The bench uses BIT_CYCLES=5, MARK_CYCLES=2, WAIT_PERIODS=5 and DATA_BITS=8. The odd bit period makes the two half-delays unequal, so an off-by-one in the mid-bit sampling shows up. The short period also makes it cheap to run every one of the 256 byte values three times. Each value is sent by the bench with correct parity and with flipped parity, and each is sent by the transmitter in loopback with the transmitted waveform compared cycle by cycle. The wait bound of 25 cycles is short enough to exercise the timeout path with a wire held high.

// File: rtl/swp_pkg.sv
package swp_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_SYNC,
        TX_MARK,
        TX_DATA
    } tx_state_e;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_WLOW,
        RX_WHIGH,
        RX_LEAD,
        RX_BITS,
        RX_TAIL
    } rx_state_e;

endpackage

// File: rtl/swp_sync.sv
module swp_sync #(
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    typedef struct packed {
        logic s1;
        logic s2;
    } sync_t;

    sync_t r_d, r_q;

    always_comb begin
        r_d.s1 = d;
        r_d.s2 = r_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{s1: IDLE_LEVEL, s2: IDLE_LEVEL};
        else        r_q <= r_d;
    end

    assign q = r_q.s2;
endmodule

// File: rtl/swp_tx.sv
module swp_tx
    import swp_pkg::*;
#(
    parameter int BIT_CYCLES  = 96,
    parameter int MARK_CYCLES = 2,
    parameter int DATA_BITS   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [DATA_BITS-1:0] data,
    output logic                 line_oe,
    output logic                 line_out,
    output logic                 busy,
    output logic                 done
);
    localparam int CMAX = (BIT_CYCLES > MARK_CYCLES) ? BIT_CYCLES : MARK_CYCLES;
    localparam int CW   = $clog2(CMAX + 1);
    localparam int IW   = $clog2(DATA_BITS + 1);

    typedef struct packed {
        tx_state_e          st;
        logic [CW-1:0]      cnt;
        logic [IW-1:0]      idx;
        logic [DATA_BITS:0] sh;
        logic               parked;
        logic               done;
    } tx_regs_t;

    tx_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            TX_IDLE: begin
                if (start) begin
                    r_d.st  = TX_SYNC;
                    r_d.cnt = '0;
                    r_d.sh  = {data, ^data};
                end
            end
            TX_SYNC: begin
                if (r_q.cnt == CW'(BIT_CYCLES - 1)) begin
                    r_d.st  = TX_MARK;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            TX_MARK: begin
                if (r_q.cnt == CW'(MARK_CYCLES - 1)) begin
                    r_d.st  = TX_DATA;
                    r_d.cnt = '0;
                    r_d.idx = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            TX_DATA: begin
                if (r_q.cnt == CW'(BIT_CYCLES - 1)) begin
                    r_d.cnt = '0;
                    if (r_q.idx == IW'(DATA_BITS)) begin
                        r_d.st     = TX_IDLE;
                        r_d.parked = 1'b1;
                        r_d.done   = 1'b1;
                    end else begin
                        r_d.idx = r_q.idx + IW'(1);
                        r_d.sh  = {r_q.sh[DATA_BITS-1:0], 1'b0};
                    end
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            default: r_d.st = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: TX_IDLE, cnt: '0, idx: '0, sh: '0, parked: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy     = (r_q.st != TX_IDLE);
    assign done     = r_q.done;
    assign line_oe  = busy || r_q.parked;
    assign line_out = (r_q.st == TX_MARK) ||
                      ((r_q.st == TX_DATA) && r_q.sh[DATA_BITS]);
endmodule

// File: rtl/swp_rx.sv
module swp_rx
    import swp_pkg::*;
#(
    parameter int BIT_CYCLES   = 96,
    parameter int MARK_CYCLES  = 2,
    parameter int WAIT_PERIODS = 5,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 arm,
    input  logic                 s,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 perr
);
    localparam int HALF1      = BIT_CYCLES / 2;
    localparam int HALF2      = BIT_CYCLES - HALF1;
    localparam int LEAD_LEN   = MARK_CYCLES + HALF1;
    localparam int WAIT_LIMIT = WAIT_PERIODS * BIT_CYCLES;
    localparam int CMAX_A     = (WAIT_LIMIT > LEAD_LEN) ? WAIT_LIMIT : LEAD_LEN;
    localparam int CMAX       = (CMAX_A > BIT_CYCLES) ? CMAX_A : BIT_CYCLES;
    localparam int CW         = $clog2(CMAX + 1);
    localparam int IW         = $clog2(DATA_BITS + 1);

    typedef struct packed {
        rx_state_e            st;
        logic [CW-1:0]        cnt;
        logic [IW-1:0]        idx;
        logic [DATA_BITS:0]   sh;
        logic [DATA_BITS-1:0] data;
        logic                 perr;
        logic                 done;
    } rx_regs_t;

    rx_regs_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            RX_IDLE: begin
                if (arm) begin
                    r_d.st  = RX_WLOW;
                    r_d.cnt = '0;
                end
            end
            RX_WLOW: begin
                if (!s) begin
                    r_d.st = RX_WHIGH;
                end else if (r_q.cnt == CW'(WAIT_LIMIT - 1)) begin
                    r_d.st  = RX_LEAD;
                    r_d.cnt = '0;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            RX_WHIGH: begin
                if (s) begin
                    r_d.st  = RX_LEAD;
                    r_d.cnt = '0;
                end
            end
            RX_LEAD: begin
                if (r_q.cnt == CW'(LEAD_LEN - 1)) begin
                    r_d.sh  = {r_q.sh[DATA_BITS-1:0], s};
                    r_d.st  = RX_BITS;
                    r_d.cnt = '0;
                    r_d.idx = IW'(1);
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            RX_BITS: begin
                if (r_q.cnt == CW'(BIT_CYCLES - 1)) begin
                    r_d.sh  = {r_q.sh[DATA_BITS-1:0], s};
                    r_d.cnt = '0;
                    if (r_q.idx == IW'(DATA_BITS)) r_d.st  = RX_TAIL;
                    else                           r_d.idx = r_q.idx + IW'(1);
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            RX_TAIL: begin
                if (r_q.cnt == CW'(HALF2 - 1)) begin
                    r_d.st   = RX_IDLE;
                    r_d.done = 1'b1;
                    r_d.data = r_q.sh[DATA_BITS:1];
                    r_d.perr = ^r_q.sh;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            default: r_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: RX_IDLE, cnt: '0, idx: '0, sh: '0, data: '0, perr: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign busy = (r_q.st != RX_IDLE);
    assign done = r_q.done;
    assign data = r_q.data;
    assign perr = r_q.perr;
endmodule

// File: rtl/sw_parity_xcvr.sv
module sw_parity_xcvr #(
    parameter int BIT_CYCLES   = 96,
    parameter int MARK_CYCLES  = 2,
    parameter int WAIT_PERIODS = 5,
    parameter int DATA_BITS    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tx_start,
    input  logic [DATA_BITS-1:0] tx_data,
    output logic                 tx_busy,
    output logic                 tx_done,
    output logic                 line_oe,
    output logic                 line_out,
    input  logic                 line_in,
    input  logic                 rx_arm,
    output logic                 rx_busy,
    output logic                 rx_done,
    output logic [DATA_BITS-1:0] rx_data,
    output logic                 rx_perr
);
    logic line_s;

    swp_tx #(
        .BIT_CYCLES (BIT_CYCLES),
        .MARK_CYCLES(MARK_CYCLES),
        .DATA_BITS  (DATA_BITS)
    ) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (tx_start),
        .data    (tx_data),
        .line_oe (line_oe),
        .line_out(line_out),
        .busy    (tx_busy),
        .done    (tx_done)
    );

    swp_sync #(.IDLE_LEVEL(1'b1)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (line_in),
        .q    (line_s)
    );

    swp_rx #(
        .BIT_CYCLES  (BIT_CYCLES),
        .MARK_CYCLES (MARK_CYCLES),
        .WAIT_PERIODS(WAIT_PERIODS),
        .DATA_BITS   (DATA_BITS)
    ) u_rx (
        .clk  (clk),
        .rst_n(rst_n),
        .arm  (rx_arm),
        .s    (line_s),
        .busy (rx_busy),
        .done (rx_done),
        .data (rx_data),
        .perr (rx_perr)
    );
endmodule

// File: rtl/swp_chk.sv
module swp_chk #(
    parameter int DATA_BITS = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 tx_busy,
    input logic                 tx_done,
    input logic                 line_oe,
    input logic                 line_out,
    input logic                 rx_busy,
    input logic                 rx_done,
    input logic [DATA_BITS-1:0] rx_data,
    input logic                 rx_perr
);
    assert_sync_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_busy) |-> (line_oe && !line_out));

    assert_busy_drives_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy |-> line_oe);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |=> !tx_done);

    assert_park_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_done |-> (line_oe && !line_out && !tx_busy));

    assert_park_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (line_oe && !tx_busy) |=> (line_oe && !line_out));

    assert_rx_done_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |-> (!rx_busy && $past(rx_busy)));

    assert_rx_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_data) |-> rx_done);

    assert_rx_perr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_perr) |-> rx_done);
endmodule

bind sw_parity_xcvr swp_chk #(.DATA_BITS(DATA_BITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_busy (tx_busy),
    .tx_done (tx_done),
    .line_oe (line_oe),
    .line_out(line_out),
    .rx_busy (rx_busy),
    .rx_done (rx_done),
    .rx_data (rx_data),
    .rx_perr (rx_perr)
);

// File: tb/sw_parity_xcvr_bench.sv
module sw_parity_xcvr_bench;
    localparam int BITC = 5;
    localparam int MRK  = 2;
    localparam int WP   = 5;
    localparam int W    = 8;
    localparam int RX_EXP  = BITC + 3 + MRK + 9 * BITC;
    localparam int TO_EXP  = 1 + WP * BITC + MRK + 9 * BITC;
    localparam int TX_LEN  = 10 * BITC + MRK;
    localparam int LB_RXE  = BITC + 1 + 3 + MRK + 9 * BITC;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tx_start = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic tx_busy, tx_done, line_oe, line_out, line_in;
    logic rx_arm = 1'b0;
    logic rx_busy, rx_done, rx_perr;
    logic [W-1:0] rx_data;
    logic drv = 1'b1;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign line_in = (line_oe ? line_out : 1'b1) & drv;

    sw_parity_xcvr #(
        .BIT_CYCLES(BITC), .MARK_CYCLES(MRK), .WAIT_PERIODS(WP), .DATA_BITS(W)
    ) u_sw_parity_xcvr (
        .clk(clk), .rst_n(rst_n),
        .tx_start(tx_start), .tx_data(tx_data), .tx_busy(tx_busy), .tx_done(tx_done),
        .line_oe(line_oe), .line_out(line_out), .line_in(line_in),
        .rx_arm(rx_arm), .rx_busy(rx_busy), .rx_done(rx_done),
        .rx_data(rx_data), .rx_perr(rx_perr)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tx_start = 1'b0; rx_arm = 1'b0; drv = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    function automatic logic frame_bit(input int j, input logic [W-1:0] b, input logic par);
        int k;
        if (j < BITC) return 1'b0;
        if (j < BITC + MRK) return 1'b1;
        k = (j - BITC - MRK) / BITC;
        if (k < W) return b[W-1-k];
        if (k == W) return par;
        return 1'b0;
    endfunction

    // R7 R8 R9 R11: bench drives a frame, receiver decodes it
    task automatic rx_frame(input logic [W-1:0] b, input bit bad, input bit extra_arm);
        logic par;
        par = (^b) ^ bad;
        for (int i = 0; i <= RX_EXP + 2; i++) begin
            @(negedge clk);
            rx_arm = (i == 0) || (extra_arm && i == 30);
            drv = (i < 10 * BITC + MRK) ? frame_bit(i, b, par) : 1'b1;
            chk(rx_done == (i == RX_EXP), "R8 rx_done timing", int'(rx_done), int'(i == RX_EXP));
            if (i == RX_EXP) begin
                chk(rx_data == b, extra_arm ? "R11 rx_data" : "R8 rx_data", int'(rx_data), int'(b));
                chk(rx_perr == bad, "R9 rx_perr", int'(rx_perr), int'(bad));
            end
        end
        rx_arm = 1'b0;
        drv = 1'b1;
    endtask

    // R2 R3 R4 R5 R6: transmit waveform, looped back into the receiver
    task automatic tx_frame(input logic [W-1:0] b, input bit bump);
        int j;
        for (int i = 0; i <= TX_LEN + 6; i++) begin
            @(negedge clk);
            tx_start = (i == 0) || (bump && i == 21);
            rx_arm   = (i == 0) || (bump && i == 21);
            tx_data  = (bump && i == 21) ? ~b : b;
            if (i >= 1) begin
                j = i - 1;
                chk(line_oe == 1'b1, "R5 line_oe", int'(line_oe), 1);
                if (j < BITC + MRK)
                    chk(line_out == frame_bit(j, b, ^b), "R2 sync", int'(line_out), int'(frame_bit(j, b, ^b)));
                else if (j < BITC + MRK + W * BITC)
                    chk(line_out == frame_bit(j, b, ^b), bump ? "R6 data" : "R3 data", int'(line_out), int'(frame_bit(j, b, ^b)));
                else
                    chk(line_out == frame_bit(j, b, ^b), "R4 parity or R5 park", int'(line_out), int'(frame_bit(j, b, ^b)));
                chk(tx_busy == (j < TX_LEN), "R5 tx_busy", int'(tx_busy), int'(j < TX_LEN));
                chk(tx_done == (j == TX_LEN), "R5 tx_done", int'(tx_done), int'(j == TX_LEN));
            end
            if (i == LB_RXE) begin
                chk(rx_done == 1'b1, "R8 loopback done", int'(rx_done), 1);
                chk(rx_data == b, "R8 loopback data", int'(rx_data), int'(b));
                chk(rx_perr == 1'b0, "R4 loopback parity", int'(rx_perr), 0);
            end
        end
        tx_start = 1'b0;
        rx_arm = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        chk(line_oe == 1'b0, "R1 line_oe", int'(line_oe), 0);
        chk(tx_busy == 1'b0, "R1 tx_busy", int'(tx_busy), 0);
        chk(tx_done == 1'b0, "R1 tx_done", int'(tx_done), 0);
        chk(rx_busy == 1'b0, "R1 rx_busy", int'(rx_busy), 0);
        chk(rx_done == 1'b0, "R1 rx_done", int'(rx_done), 0);
        chk(rx_data == '0, "R1 rx_data", int'(rx_data), 0);
        chk(rx_perr == 1'b0, "R1 rx_perr", int'(rx_perr), 0);

        for (int v = 0; v < 256; v++) rx_frame(W'(v), 1'b0, v == 8'h33);
        for (int v = 0; v < 256; v++) rx_frame(W'(v), 1'b1, 1'b0);

        // R10 timeout with the wire held high
        do_reset();
        for (int i = 0; i <= TO_EXP + 2; i++) begin
            @(negedge clk);
            rx_arm = (i == 0);
            if (i >= 1) begin
                chk(rx_busy == (i < TO_EXP), "R10 rx_busy", int'(rx_busy), int'(i < TO_EXP));
                chk(rx_done == (i == TO_EXP), "R10 rx_done", int'(rx_done), int'(i == TO_EXP));
            end
            if (i == TO_EXP) begin
                chk(rx_data == 8'hFF, "R10 rx_data", int'(rx_data), 255);
                chk(rx_perr == 1'b1, "R10 rx_perr", int'(rx_perr), 1);
            end
        end
        rx_arm = 1'b0;

        do_reset();
        for (int v = 0; v < 256; v++) tx_frame(W'(v), v == 8'h5A);

        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule